// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block keeps a pair of result registers, HI and LO, and fills them with the outcome of multiply and divide commands. Each command comes with two operands. A command may be signed or unsigned. A multiply leaves the full double-width product split across the pair. A divide leaves the quotient in LO and the remainder in HI. The work is done one bit per clock: a shift-and-add loop for products and a restoring loop for quotients. A setup cycle comes first and computes operand magnitudes and result signs. Sign correction is applied as the last step writes the pair.

A host pulses `start` with an operation code. Arithmetic codes raise `busy` until the pair is written. Read codes copy HI or LO onto `rd_data` one clock later. Reads are served at any time, including during a running command. While a command runs, the pair keeps the values of the last completed command. An arithmetic start that arrives while the unit is busy is dropped.

Top module: `hilo_muldiv_unit`

## Requirements
- R1: After reset, busy is low, rd_data is zero, and both HI and LO read back as zero.
- R2: The op field selects as follows: 3'b000 signed multiply, 3'b001 unsigned multiply, 3'b010 signed divide, 3'b011 unsigned divide, 3'b100 read HI, 3'b101 read LO. An op is acted on only in a cycle where start is high.
- R3: A multiply writes the upper WIDTH bits of the 2*WIDTH-bit product to HI and the lower WIDTH bits to LO. The product is two's complement for the signed form and plain binary for the unsigned form.
- R4: A divide writes the quotient to LO and the remainder to HI. The signed quotient truncates toward zero, and the signed remainder carries the dividend's sign. For a signed most-negative dividend divided by -1, LO holds the most-negative value and HI holds zero.
- R5: busy is high from the first clock edge after an accepted arithmetic start. It stays high for exactly WIDTH+1 cycles (33 by default). It falls on the same edge that writes HI and LO.
- R6: A divide by zero raises nothing. An unsigned divide by zero leaves LO all ones and HI equal to the dividend. A signed divide by zero leaves HI equal to the dividend, and LO is all ones for a non-negative dividend or 1 for a negative dividend.
- R7: An arithmetic start while busy is high is ignored. The command already running completes with its own operands.
- R8: A read op loads HI or LO into rd_data at the next clock edge. rd_data holds its value in every other cycle.
- R9: A read issued while busy returns the HI/LO values of the last completed command.
- R10: The op codes 3'b110 and 3'b111 change neither busy, nor rd_data, nor HI, nor LO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, one cycle per command |
| op | input | 3 | Operation code, see R2 |
| opnd_a | input | WIDTH | Multiplicand or dividend |
| opnd_b | input | WIDTH | Multiplier or divisor |
| busy | output | 1 | High while an arithmetic command runs |
| rd_data | output | WIDTH | Read result of the last HI or LO read |

## Verification
Call the sampling edge of a start E0. An arithmetic start shows busy high right after E0. The new HI/LO pair is written at E0+33, which is the edge where busy falls. A read result appears on rd_data right after the edge that samples the read. The bench drives on falling edges and samples on falling edges. It counts the falling edges that see busy high and expects 33. It then reads HI and LO back one edge after each read strobe. Reads issued during a command and starts injected during a command are placed at known falling-edge counts inside the busy window, so their expected values are fixed.

// File: rtl/hilo_pkg.sv
package hilo_pkg;

   typedef enum logic [2:0] {
      OP_MULS = 3'b000,
      OP_MULU = 3'b001,
      OP_DIVS = 3'b010,
      OP_DIVU = 3'b011,
      OP_RDHI = 3'b100,
      OP_RDLO = 3'b101
   } hilo_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PREP = 2'd1,
      ST_ITER = 2'd2
   } hilo_state_e;

endpackage

// File: rtl/hilo_cond_neg.sv
module hilo_cond_neg #(
   parameter int unsigned W = 32
) (
   input  logic         neg_i,
   input  logic [W-1:0] val_i,
   output logic [W-1:0] val_o
);
   assign val_o = neg_i ? (~val_i + W'(1)) : val_i;
endmodule

// File: rtl/hilo_mul_step.sv
module hilo_mul_step #(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] hi_i,
   input  logic [W-1:0] lo_i,
   input  logic [W-1:0] mcand_i,
   output logic [W-1:0] hi_o,
   output logic [W-1:0] lo_o
);
   logic [W:0] sum;

   always_comb begin
      sum  = lo_i[0] ? ({1'b0, hi_i} + {1'b0, mcand_i}) : {1'b0, hi_i};
      hi_o = sum[W:1];
      lo_o = {sum[0], lo_i[W-1:1]};
   end
endmodule

// File: rtl/hilo_div_step.sv
module hilo_div_step #(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] rem_i,
   input  logic [W-1:0] quo_i,
   input  logic [W-1:0] dvsr_i,
   output logic [W-1:0] rem_o,
   output logic [W-1:0] quo_o
);
   logic [W:0] shifted;
   logic [W:0] diff;
   logic       fits;

   always_comb begin
      shifted = {rem_i, quo_i[W-1]};
      fits    = (shifted >= {1'b0, dvsr_i});
      diff    = shifted - {1'b0, dvsr_i};
      rem_o   = fits ? diff[W-1:0] : shifted[W-1:0];
      quo_o   = {quo_i[W-2:0], fits};
   end
endmodule

// File: rtl/hilo_muldiv_unit.sv
module hilo_muldiv_unit
   import hilo_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [2:0]       op,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   output logic             busy,
   output logic [WIDTH-1:0] rd_data
);

   localparam int unsigned CW   = $clog2(WIDTH);
   localparam int unsigned DW   = 2 * WIDTH;
   localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

   if (WIDTH < 4) begin : g_width_chk
      $error("hilo_muldiv_unit: WIDTH must be at least 4");
   end

   hilo_state_e      state;
   logic [CW-1:0]    cnt;
   logic [WIDTH-1:0] a_q, b_q;
   logic             sgn_q, div_q, neg_q, neg_r;
   logic [WIDTH-1:0] work_hi, work_lo, opnd_m;
   logic [WIDTH-1:0] hi_q, lo_q, rd_q;

   // operand magnitudes, one negator per operand
   logic [WIDTH-1:0] raw [2];
   logic [WIDTH-1:0] mag [2];
   assign raw[0] = a_q;
   assign raw[1] = b_q;

   for (genvar g = 0; g < 2; g++) begin : g_mag
      hilo_cond_neg #(.W(WIDTH)) u_abs (
         .neg_i (sgn_q & raw[g][WIDTH-1]),
         .val_i (raw[g]),
         .val_o (mag[g])
      );
   end

   // one iteration of each algorithm
   logic [WIDTH-1:0] mul_hi, mul_lo, div_hi, div_lo;

   hilo_mul_step #(.W(WIDTH)) u_mul (
      .hi_i    (work_hi),
      .lo_i    (work_lo),
      .mcand_i (opnd_m),
      .hi_o    (mul_hi),
      .lo_o    (mul_lo)
   );

   hilo_div_step #(.W(WIDTH)) u_div (
      .rem_i  (work_hi),
      .quo_i  (work_lo),
      .dvsr_i (opnd_m),
      .rem_o  (div_hi),
      .quo_o  (div_lo)
   );

   // sign correction applied on the final iteration
   logic [DW-1:0]    prod_fix;
   logic [WIDTH-1:0] quo_fix, rem_fix;

   hilo_cond_neg #(.W(DW)) u_fix_prod (
      .neg_i (neg_q),
      .val_i ({mul_hi, mul_lo}),
      .val_o (prod_fix)
   );

   hilo_cond_neg #(.W(WIDTH)) u_fix_quo (
      .neg_i (neg_q),
      .val_i (div_lo),
      .val_o (quo_fix)
   );

   hilo_cond_neg #(.W(WIDTH)) u_fix_rem (
      .neg_i (neg_r),
      .val_i (div_hi),
      .val_o (rem_fix)
   );

   logic [WIDTH-1:0] step_hi, step_lo, res_hi, res_lo;

   always_comb begin
      step_hi = div_q ? div_hi : mul_hi;
      step_lo = div_q ? div_lo : mul_lo;
      res_hi  = div_q ? rem_fix : prod_fix[DW-1:WIDTH];
      res_lo  = div_q ? quo_fix : prod_fix[WIDTH-1:0];
   end

   // sequencing
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         a_q     <= '0;
         b_q     <= '0;
         sgn_q   <= 1'b0;
         div_q   <= 1'b0;
         neg_q   <= 1'b0;
         neg_r   <= 1'b0;
         work_hi <= '0;
         work_lo <= '0;
         opnd_m  <= '0;
         hi_q    <= '0;
         lo_q    <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start && !op[2]) begin
                  a_q   <= opnd_a;
                  b_q   <= opnd_b;
                  sgn_q <= ~op[0];
                  div_q <= op[1];
                  state <= ST_PREP;
               end
            end
            ST_PREP: begin
               work_hi <= '0;
               work_lo <= mag[0];
               opnd_m  <= mag[1];
               neg_q   <= sgn_q & (a_q[WIDTH-1] ^ b_q[WIDTH-1]);
               neg_r   <= sgn_q & a_q[WIDTH-1];
               cnt     <= '0;
               state   <= ST_ITER;
            end
            ST_ITER: begin
               work_hi <= step_hi;
               work_lo <= step_lo;
               cnt     <= cnt + CW'(1);
               if (cnt == LAST) begin
                  hi_q  <= res_hi;
                  lo_q  <= res_lo;
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // read port
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q <= '0;
      end else if (start && op == OP_RDHI) begin
         rd_q <= hi_q;
      end else if (start && op == OP_RDLO) begin
         rd_q <= lo_q;
      end
   end

   assign busy    = (state != ST_IDLE);
   assign rd_data = rd_q;

   AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start && !op[2])); // R5
   AST_HILO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(hi_q) && $stable(lo_q))); // R9
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(a_q) && $stable(b_q) && $stable(div_q))); // R7
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(rd_data)); // R8
   AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ITER && div_q && opnd_m == '0) |=> work_lo[0]); // R6
   AST_RSVD_OP: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op[2] && op[1] && !busy) |=> !busy); // R10

endmodule

// File: tb/sim_hilo_muldiv_unit.sv
`timescale 1ns/1ps
module sim_hilo_muldiv_unit;
   import hilo_pkg::*;

   localparam time CYC = 20ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op = 3'b000;
   logic [31:0] a = '0;
   logic [31:0] b = '0;
   logic        busy;
   logic [31:0] rd_data;

   int nchk = 0;
   int nfail = 0;
   logic [31:0] exp_hi = '0;
   logic [31:0] exp_lo = '0;

   hilo_muldiv_unit #(.WIDTH(32)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op),
      .opnd_a(a), .opnd_b(b), .busy(busy), .rd_data(rd_data)
   );

   always #(CYC/2) clk = ~clk;

   function automatic logic [63:0] model(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
      longint sx, sy, p, q, r;
      logic [63:0] pv, qv, rv;
      sx = longint'($signed(x));
      sy = longint'($signed(y));
      case (o)
         3'b000: begin p = sx * sy; pv = p; return pv; end
         3'b001: return {32'b0, x} * {32'b0, y};
         3'b010: begin
            if (y == 0) return {x, (x[31] ? 32'h1 : 32'hFFFF_FFFF)};
            q = sx / sy; r = sx % sy; qv = q; rv = r;
            return {rv[31:0], qv[31:0]};
         end
         default: begin
            if (y == 0) return {x, 32'hFFFF_FFFF};
            return {x % y, x / y};
         end
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] o, input logic [31:0] exp, input string req);
      @(negedge clk); start = 1'b1; op = o;
      @(negedge clk); start = 1'b0;
      chk(req, rd_data, exp);
      @(negedge clk);
      chk("R8 rd_data hold", rd_data, exp);
   endtask

   task automatic arith(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y,
                        input bit inject, input string req);
      logic [63:0] r;
      int n;
      r = model(o, x, y);
      @(negedge clk); start = 1'b1; op = o; a = x; b = y;
      @(negedge clk); start = 1'b0;
      chk("R5 busy rise", {31'b0, busy}, 32'd1);
      n = 1;
      while (busy && n < 100) begin
         if (n == 3) begin start = 1'b1; op = OP_RDHI; end
         if (n == 4) begin start = 1'b0; chk("R9 read during busy", rd_data, exp_hi); end
         if (inject && n == 10) begin
            start = 1'b1; op = 3'($urandom % 4); a = $urandom; b = $urandom;
         end
         if (n == 11) start = 1'b0;
         @(negedge clk);
         if (busy) n++;
      end
      chk("R5 busy length", 32'(n), 32'd33);
      exp_hi = r[63:32];
      exp_lo = r[31:0];
      rd(OP_RDHI, exp_hi, inject ? {req, " R7 HI"} : {req, " HI"});
      rd(OP_RDLO, exp_lo, inject ? {req, " R7 LO"} : {req, " LO"});
   endtask

   initial begin
      #(CYC * 150000);
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy after reset", {31'b0, busy}, 32'd0);
      chk("R1 rd_data after reset", rd_data, 32'd0);
      rd(OP_RDHI, 32'd0, "R1 HI after reset");
      rd(OP_RDLO, 32'd0, "R1 LO after reset");

      // R3 directed products
      arith(3'b000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R3 signed -1*-1");
      arith(3'b001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R3 unsigned max*max");
      arith(3'b000, 32'h8000_0000, 32'h8000_0000, 1'b0, "R3 signed min*min");
      arith(3'b000, 32'd7, 32'hFFFF_FFFD, 1'b0, "R3 signed 7*-3");
      // R4 directed quotients
      arith(3'b010, 32'hFFFF_FFF9, 32'd2, 1'b0, "R4 signed -7/2");
      arith(3'b010, 32'd7, 32'hFFFF_FFFE, 1'b0, "R4 signed 7/-2");
      arith(3'b010, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, "R4 signed min/-1");
      arith(3'b011, 32'hFFFF_FFF9, 32'd2, 1'b0, "R4 unsigned big/2");
      arith(3'b011, 32'd0, 32'd5, 1'b0, "R4 unsigned 0/5");
      // R6 divide by zero
      arith(3'b010, 32'h0000_1234, 32'd0, 1'b0, "R6 signed pos/0");
      arith(3'b010, 32'hFFFF_0000, 32'd0, 1'b0, "R6 signed neg/0");
      arith(3'b011, 32'hDEAD_BEEF, 32'd0, 1'b0, "R6 unsigned /0");
      // R2 R3 R4 random mix, R7 injected starts
      for (int i = 0; i < 40; i++) begin
         logic [2:0] o;
         o = 3'($urandom % 4);
         arith(o, $urandom, (i % 7 == 6) ? 32'($urandom % 9) : $urandom,
               (i % 4 == 0), o[1] ? "R2 R4 random divide" : "R2 R3 random multiply");
      end
      // R10 reserved codes
      for (int k = 6; k < 8; k++) begin
         @(negedge clk); start = 1'b1; op = 3'(k); a = $urandom; b = $urandom;
         @(negedge clk); start = 1'b0;
         chk("R10 reserved busy", {31'b0, busy}, 32'd0);
         chk("R10 reserved rd_data", rd_data, exp_lo);
      end
      rd(OP_RDHI, exp_hi, "R10 HI unchanged");
      rd(OP_RDLO, exp_lo, "R10 LO unchanged");

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

endmodule